// File: doc/BRIEF.md
# Pulse-Position Nibble Decoder with Sync Preamble

This block recovers 4-bit values from a serial read line in which every value is carried by the position of a falling edge. A cycle opens with a start edge. A second falling edge, the data edge, lands somewhere inside a one-microsecond window that opens two microseconds later. The line is sampled at sixteen ticks per microsecond, so the tick offset of the data edge inside the window is the value itself. A line that has been idle for some time cannot tell start edges apart from data edges. For that reason a stream begins with a preamble of falling edges spaced four microseconds apart. That gap is longer than any gap that occurs inside a nibble, so it marks which edge is a start.

The host raises a one-cycle arm input after an index mark or a sector header. The decoder then hunts for the preamble and locks after two consecutive long gaps. From that point it emits one strobed nibble per cycle. After a data edge the next start edge may follow at any distance of two microseconds or more, so cycles need not all be the same length. A data edge outside the window, a missing data edge, or a start edge that comes too early produces a one-cycle error pulse and sends the decoder back to hunting. Recovering the rate of the sample clock is left to the surrounding logic.

Top module: `ppd_nibble_rx`

## Requirements
- R1: After reset all outputs are low and the decoder stays idle: falling edges on the line produce no nibble, sync or error event until `arm` is pulsed.
- R2: The line passes through a two-flop synchroniser. Only a high-to-low change between successive synchronised samples counts as an edge, and a rising edge has no effect. An event caused by a fall is visible at the outputs after the third rising clock edge following the fall.
- R3: After `arm`, edges are not decoded until two consecutive inter-edge gaps of at least 56 ticks have been seen. A shorter gap between them restarts the search. The first edge after lock that follows a gap shorter than 56 ticks is taken as a cycle start.
- R4: `sync_flag` pulses for one cycle for every edge that ends a gap of at least 56 ticks, either while hunting or while locked and waiting for the first start. A gap of 55 ticks is not a sync gap.
- R5: The 6-bit interval counter restarts at every accepted edge and at `arm`, and it saturates at 63 instead of wrapping. A gap of any length above 63 ticks therefore still counts as a sync gap.
- R6: A data edge that arrives N ticks after its cycle start, with 32 <= N <= 47, gives one `nib_valid` cycle with `nib_value` = N - 32. So 32 ticks gives 0x0 and 47 ticks gives 0xF.
- R7: A data edge with N < 32 or N >= 48 gives a one-cycle `err_flag` and no nibble. The decoder then hunts again, and no later edge is decoded until a new lock.
- R8: If no data edge arrives, `err_flag` pulses once the count since the start reaches 48 ticks. This is the 51st clock after the start fall at the pin, counting the synchroniser.
- R9: After a data edge, any following edge at 32 ticks or more is the next cycle start, even one far beyond 63 ticks. An edge sooner than 32 ticks gives `err_flag` and a return to hunting.
- R10: `arm` takes priority in every state. It clears the lock and restarts the hunt for two sync gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 16 ticks per microsecond |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_line | input | 1 | Raw asynchronous read-data line, idle high |
| arm | input | 1 | One-cycle pulse that starts the hunt for a preamble |
| nib_valid | output | 1 | One-cycle strobe for a decoded value |
| nib_value | output | 4 | Decoded value, meaningful while nib_valid is high |
| sync_flag | output | 1 | One-cycle pulse when a sync gap is recognised |
| err_flag | output | 1 | One-cycle pulse on a timing violation |

## Verification
On every cycle the bound checker confirms the following. A strobe, a sync pulse and an error are never raised together. Every nibble follows an edge whose count lay inside the window, and its value matches that count. Every sync pulse follows an edge that ended a long gap. The counter never wraps past its top value. An error never lasts two cycles, and arm silences the outputs on the cycle after it.

Several behaviours involve whole sequences of edges, so only the bench scenarios can show them. These are the need for two consecutive sync gaps before lock, idling before arm, the 51-clock timeout, free-length cycles after a data edge, and the three-clock latency through the synchroniser. The bench sweeps all sixteen window positions with varied trailing gaps, and it probes each boundary tick on both sides.

// File: rtl/ppd_pkg.sv
package ppd_pkg;

    // Decoder phases
    typedef enum logic [2:0] {
        PPD_IDLE,   // waiting for arm
        PPD_HUNT,   // counting consecutive long gaps
        PPD_LOCK,   // preamble seen, next short-gap edge opens a cycle
        PPD_DATA,   // cycle open, waiting for the data edge
        PPD_WAIT    // value taken, waiting for the next cycle start
    } ppd_state_e;

endpackage

// File: rtl/ppd_edge_sync.sv
module ppd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);

    // sh[0..STAGES-1] are the synchroniser, sh[STAGES] holds the previous sample
    logic [STAGES:0] sh_d, sh_q;

    assign sh_d[0] = din;
    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        assign sh_d[i] = sh_q[i-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];

endmodule

// File: rtl/ppd_interval_timer.sv
module ppd_interval_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] TOP  = '1;
    // Restart value: the tick of the restarting edge is already counted,
    // so the next edge reads the number of ticks elapsed.
    localparam logic [CNT_W-1:0] BASE = CNT_W'(1);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (restart)             count_d = BASE;
        else if (count_q != TOP) count_d = count_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= TOP;
        else        count_q <= count_d;
    end

    assign count = count_q;

endmodule

// File: rtl/ppd_classifier.sv
module ppd_classifier
    import ppd_pkg::*;
#(
    parameter int CNT_W     = 6,
    parameter int VAL_W     = 4,
    parameter int WIN_LO    = 32,
    parameter int WIN_HI    = 47,
    parameter int GAP_MIN   = 32,
    parameter int SYNC_MIN  = 56,
    parameter int SYNC_RUNS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             fall,
    input  logic [CNT_W-1:0] count,
    output logic             restart,
    output logic             nib_valid,
    output logic [VAL_W-1:0] nib_value,
    output logic             sync_flag,
    output logic             err_flag
);

    localparam int RUN_W = $clog2(SYNC_RUNS + 1);
    localparam logic [CNT_W-1:0] WIN_LO_C   = CNT_W'(WIN_LO);
    localparam logic [CNT_W-1:0] WIN_HI_C   = CNT_W'(WIN_HI);
    localparam logic [CNT_W-1:0] GAP_MIN_C  = CNT_W'(GAP_MIN);
    localparam logic [CNT_W-1:0] SYNC_MIN_C = CNT_W'(SYNC_MIN);
    localparam logic [RUN_W-1:0] RUN_LAST   = RUN_W'(SYNC_RUNS - 1);

    typedef struct packed {
        ppd_state_e       state;
        logic [RUN_W-1:0] run;
        logic             valid;
        logic [VAL_W-1:0] nib;
        logic             sync;
        logic             err;
    } cls_t;

    cls_t r_d, r_q;
    logic long_gap, in_window;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.sync  = 1'b0;
        r_d.err   = 1'b0;
        restart   = 1'b0;
        long_gap  = (count >= SYNC_MIN_C);
        in_window = (count >= WIN_LO_C) && (count <= WIN_HI_C);

        if (arm) begin
            r_d.state = PPD_HUNT;
            r_d.run   = '0;
            restart   = 1'b1;
        end else begin
            unique case (r_q.state)
                PPD_IDLE: ;
                PPD_HUNT: begin
                    if (fall) begin
                        restart = 1'b1;
                        if (long_gap) begin
                            r_d.sync = 1'b1;
                            if (r_q.run == RUN_LAST) begin
                                r_d.state = PPD_LOCK;
                                r_d.run   = '0;
                            end else begin
                                r_d.run = r_q.run + RUN_W'(1);
                            end
                        end else begin
                            r_d.run = '0;
                        end
                    end
                end
                PPD_LOCK: begin
                    if (fall) begin
                        restart = 1'b1;
                        if (long_gap) r_d.sync  = 1'b1;
                        else          r_d.state = PPD_DATA;
                    end
                end
                PPD_DATA: begin
                    if (fall && in_window) begin
                        restart   = 1'b1;
                        r_d.valid = 1'b1;
                        r_d.nib   = VAL_W'(count - WIN_LO_C);
                        r_d.state = PPD_WAIT;
                    end else if (fall || count > WIN_HI_C) begin
                        restart   = 1'b1;
                        r_d.err   = 1'b1;
                        r_d.state = PPD_HUNT;
                        r_d.run   = '0;
                    end
                end
                PPD_WAIT: begin
                    if (fall) begin
                        restart = 1'b1;
                        if (count < GAP_MIN_C) begin
                            r_d.err   = 1'b1;
                            r_d.state = PPD_HUNT;
                            r_d.run   = '0;
                        end else begin
                            r_d.state = PPD_DATA;
                        end
                    end
                end
                default: r_d.state = PPD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= PPD_IDLE;
            r_q.run   <= '0;
            r_q.valid <= 1'b0;
            r_q.nib   <= '0;
            r_q.sync  <= 1'b0;
            r_q.err   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign nib_valid = r_q.valid;
    assign nib_value = r_q.nib;
    assign sync_flag = r_q.sync;
    assign err_flag  = r_q.err;

endmodule

// File: rtl/ppd_nibble_rx.sv
module ppd_nibble_rx #(
    parameter int SYNC_STAGES    = 2,
    parameter int TICKS_PER_US   = 16,
    parameter int CNT_W          = 6,
    parameter int WIN_START_US   = 2,
    parameter int SYNC_MIN_TICKS = 56,
    parameter int SYNC_RUNS      = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_line,
    input  logic                            arm,
    output logic                            nib_valid,
    output logic [$clog2(TICKS_PER_US)-1:0] nib_value,
    output logic                            sync_flag,
    output logic                            err_flag
);

    localparam int VAL_W   = $clog2(TICKS_PER_US);
    localparam int WIN_LO  = WIN_START_US * TICKS_PER_US;
    localparam int WIN_HI  = WIN_LO + TICKS_PER_US - 1;
    localparam int GAP_MIN = WIN_LO;

    logic             fall_w;
    logic             restart_w;
    logic [CNT_W-1:0] cnt_w;

    ppd_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rd_line),
        .fall  (fall_w)
    );

    ppd_interval_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart_w),
        .count   (cnt_w)
    );

    ppd_classifier #(
        .CNT_W     (CNT_W),
        .VAL_W     (VAL_W),
        .WIN_LO    (WIN_LO),
        .WIN_HI    (WIN_HI),
        .GAP_MIN   (GAP_MIN),
        .SYNC_MIN  (SYNC_MIN_TICKS),
        .SYNC_RUNS (SYNC_RUNS)
    ) u_cls (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .fall      (fall_w),
        .count     (cnt_w),
        .restart   (restart_w),
        .nib_valid (nib_valid),
        .nib_value (nib_value),
        .sync_flag (sync_flag),
        .err_flag  (err_flag)
    );

endmodule

// File: rtl/ppd_checker.sv
module ppd_checker #(
    parameter int CNT_W    = 6,
    parameter int VAL_W    = 4,
    parameter int WIN_LO   = 32,
    parameter int WIN_HI   = 47,
    parameter int SYNC_MIN = 56
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm,
    input logic             fall,
    input logic [CNT_W-1:0] count,
    input logic             nib_valid,
    input logic [VAL_W-1:0] nib_value,
    input logic             sync_flag,
    input logic             err_flag
);

    localparam logic [CNT_W-1:0] LO_C   = CNT_W'(WIN_LO);
    localparam logic [CNT_W-1:0] HI_C   = CNT_W'(WIN_HI);
    localparam logic [CNT_W-1:0] SMIN_C = CNT_W'(SYNC_MIN);
    localparam logic [CNT_W-1:0] TOP_C  = '1;
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    assert_events_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nib_valid, sync_flag, err_flag}));

    assert_valid_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nib_valid |-> $past(fall) && $past(count) >= LO_C && $past(count) <= HI_C);

    assert_value_from_position_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nib_valid |-> nib_value == VAL_W'($past(count) - LO_C));

    assert_sync_needs_long_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_flag |-> $past(fall) && $past(count) >= SMIN_C);

    assert_counter_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(count) == TOP_C |-> count == TOP_C || count == ONE_C);

    assert_err_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> !err_flag);

    assert_arm_silences_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(arm) |-> !nib_valid && !sync_flag && !err_flag);

endmodule

bind ppd_nibble_rx ppd_checker #(
    .CNT_W    (CNT_W),
    .VAL_W    (VAL_W),
    .WIN_LO   (WIN_LO),
    .WIN_HI   (WIN_HI),
    .SYNC_MIN (SYNC_MIN_TICKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .fall      (fall_w),
    .count     (cnt_w),
    .nib_valid (nib_valid),
    .nib_value (nib_value),
    .sync_flag (sync_flag),
    .err_flag  (err_flag)
);

// File: tb/ppd_nibble_rx_test.sv
module ppd_nibble_rx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_line = 1'b1;
    logic       arm = 1'b0;
    logic       nib_valid;
    logic [3:0] nib_value;
    logic       sync_flag;
    logic       err_flag;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    int n_valid = 0, n_sync = 0, n_err = 0;
    int last_val = 0, last_valid_cyc = 0, last_err_cyc = 0;
    int data_cyc = 0;

    ppd_nibble_rx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_line   (rd_line),
        .arm       (arm),
        .nib_valid (nib_valid),
        .nib_value (nib_value),
        .sync_flag (sync_flag),
        .err_flag  (err_flag)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (nib_valid) begin
                n_valid++;
                last_val = int'(nib_value);
                last_valid_cyc = cyc;
            end
            if (sync_flag) n_sync++;
            if (err_flag) begin
                n_err++;
                last_err_cyc = cyc;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One fall now, line low for lowlen cycles, next fall gap cycles later
    task automatic pulse(input int gap, input int lowlen = 4);
        rd_line = 1'b0;
        repeat (lowlen) @(negedge clk);
        rd_line = 1'b1;
        repeat (gap - lowlen) @(negedge clk);
    endtask

    task automatic do_arm();
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    // Arm and send a preamble; returns where the next fall is a cycle start
    task automatic lock();
        do_arm();
        pulse(64);
        pulse(64);
        pulse(20);
    endtask

    int v0, s0, e0, st;

    initial begin
        repeat (4) @(negedge clk);
        check(!nib_valid && !sync_flag && !err_flag, "R1 reset outputs", int'({nib_valid, sync_flag, err_flag}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: edges before arm are ignored
        pulse(64); pulse(64); pulse(64); pulse(20); pulse(40); pulse(40);
        check(n_valid == 0, "R1 no nibble before arm", n_valid, 0);
        check(n_sync == 0, "R1 no sync before arm", n_sync, 0);
        check(n_err == 0, "R1 no error before arm", n_err, 0);

        // R3 / R4: broken run and 55-tick gap do not lock
        s0 = n_sync; v0 = n_valid;
        do_arm();
        pulse(10); pulse(55); pulse(64); pulse(20); pulse(40); pulse(40);
        check(n_sync - s0 == 1, "R4 gap 55 not sync", n_sync - s0, 1);
        check(n_valid == v0, "R3 no decode before two syncs", n_valid - v0, 0);
        // R4 boundary 56 locks after two gaps
        s0 = n_sync;
        pulse(56); pulse(56); pulse(20);
        check(n_sync - s0 == 2, "R4 gap 56 is sync", n_sync - s0, 2);
        pulse(35); pulse(40);
        check(n_valid - v0 == 1 && last_val == 3, "R3 decode after lock", last_val, 3);

        // R5: very long gaps saturate and still count as sync
        s0 = n_sync; v0 = n_valid;
        do_arm();
        pulse(10); pulse(200); pulse(200); pulse(20);
        check(n_sync - s0 == 2, "R5 saturating gap is sync", n_sync - s0, 2);
        pulse(40); pulse(40);
        check(n_valid - v0 == 1 && last_val == 8, "R5 decode after long preamble", last_val, 8);

        // R6 / R9 / R2: full sweep with varied trailing gaps
        lock();
        e0 = n_err;
        for (int v = 0; v < 16; v++) begin
            v0 = n_valid;
            pulse(32 + v);
            data_cyc = cyc;
            pulse(32 + (v * 13) % 70);
            check(n_valid - v0 == 1, "R6 one strobe", n_valid - v0, 1);
            check(last_val == v, "R6 value", last_val, v);
            check(last_valid_cyc - data_cyc == 3, "R2 latency", last_valid_cyc - data_cyc, 3);
        end
        check(n_err == e0, "R9 free-length cycles accepted", n_err - e0, 0);

        // R2: rising edge inside the window is ignored
        lock();
        v0 = n_valid; e0 = n_err;
        pulse(40, 38);
        pulse(40);
        check(n_valid - v0 == 1 && last_val == 8, "R2 rise ignored value", last_val, 8);
        check(n_err == e0, "R2 rise ignored no error", n_err - e0, 0);

        // R7: data edge one tick early
        lock();
        v0 = n_valid; e0 = n_err;
        pulse(31); pulse(40); pulse(40); pulse(40); pulse(40);
        check(n_err - e0 == 1, "R7 early data error", n_err - e0, 1);
        check(n_valid == v0, "R7 no decode after error", n_valid - v0, 0);

        // R7 / R8: data edge at 48 ticks
        lock();
        v0 = n_valid; e0 = n_err; st = cyc;
        pulse(48); pulse(40);
        check(n_err - e0 == 1, "R7 late data error", n_err - e0, 1);
        check(last_err_cyc - st == 51, "R7 late error timing", last_err_cyc - st, 51);
        check(n_valid == v0, "R7 late no nibble", n_valid - v0, 0);

        // R8: missing data edge
        lock();
        v0 = n_valid; e0 = n_err; st = cyc;
        pulse(100);
        check(n_err - e0 == 1, "R8 timeout error", n_err - e0, 1);
        check(last_err_cyc - st == 51, "R8 timeout timing", last_err_cyc - st, 51);

        // R9: next start too soon after data
        lock();
        v0 = n_valid; e0 = n_err;
        pulse(40); pulse(31); pulse(40);
        check(n_valid - v0 == 1 && last_val == 8, "R9 nibble before short gap", last_val, 8);
        check(n_err - e0 == 1, "R9 short gap error", n_err - e0, 1);

        // R10: arm while locked restarts the hunt
        lock();
        v0 = n_valid; s0 = n_sync;
        do_arm();
        pulse(35); pulse(40); pulse(40);
        check(n_valid == v0, "R10 arm drops lock", n_valid - v0, 0);
        check(n_sync == s0, "R10 no sync in short gaps", n_sync - s0, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule